// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Updater

This block serves the address-generation stage of a DSP-capable load/store pipeline. For each access it takes a base address register, a packed pointer register (a 16-bit index in the low half and a 16-bit buffer length or step in the high half) and a sign-extended 10-bit displacement. From these it forms the effective address, the address of the second word of a 64-bit access, and the pointer value to write back. The block does not perform the memory access itself.

Two modes are supported. In circular mode, the index moves by the displacement and wraps inside a buffer of the given length, in both the forward and the backward direction. In bit-reverse mode, the index advances by the step using reversed-bit carry propagation. This is the order in which radix-2 FFT data is visited. In both modes the address uses the index as it was before the update, so the pointer is effectively post-modified.

A one-cycle strobe starts an update. One cycle later the registered results appear with a valid pulse, and they hold until the next strobe.

Top module: `dsp_addr_updater`

## Requirements
- R1: `valid` is high exactly in the cycle after a cycle in which `start` was high, and low otherwise. All result outputs keep their values until the next strobe is taken.
- R2: `eff_addr` equals `base_addr` plus the zero-extended index `ptr_reg[15:0]`, using the index before the update.
- R3: Only `new_ptr[15:0]` can differ from `ptr_reg`. `new_ptr[31:16]` always equals `ptr_reg[31:16]`.
- R4: With `mode` = 0 (circular), let s = index + offset, taken as a signed value. If s < 0 the new index is s + length. If s >= length it is s − length. Otherwise it is s.
- R5: With `mode` = 1 (bit-reverse), the new index is rev16(rev16(index) + rev16(step)). The carry out of bit 15 is dropped and `offset` has no effect.
- R6: In circular mode, `second_addr` is base + ((index + 4) wrapped once by the length). In bit-reverse mode, `second_addr` is `eff_addr` + 4.
- R7: In circular mode with length 0, `len_err` is 1, `new_ptr` equals `ptr_reg`, and `second_addr` is `eff_addr` + 4. `len_err` is never 1 in bit-reverse mode.
- R8: While `rst_n` is low and after its release, every output is 0 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that captures a new update |
| mode | input | 1 | 0 = circular, 1 = bit-reverse |
| base_addr | input | 32 | Buffer base address register |
| ptr_reg | input | 32 | Packed pointer: [15:0] index, [31:16] length or step |
| offset | input | 10 | Signed displacement (two's complement) |
| valid | output | 1 | Result strobe, one cycle after `start` |
| eff_addr | output | 32 | Address of the (first) access |
| second_addr | output | 32 | Address of the second word of a 64-bit access |
| new_ptr | output | 32 | Pointer value to write back |
| len_err | output | 1 | Circular update requested with zero length |

## Verification
The circular mode is exercised with several cases: a plain step inside the buffer, a forward step past the end, a backward step below zero, a sum landing exactly on the length, and the most negative displacement. Together these separate the add-length path, the subtract-length path and the pass-through path, and they expose an off-by-one in the compare. The bit-reverse mode is exercised with a step from zero, a step whose reversed sum carries across bits, and a step whose carry leaves bit 15, so a missing reversal or a kept carry gives a different index. A zero length is applied in both modes to show that the error flag belongs to circular mode only. Directed cycles check that results hold between strobes and that back-to-back strobes each give a valid pulse.

// File: rtl/dsp_addr_pkg.sv
package dsp_addr_pkg;

   typedef enum logic {
      MODE_CIRC = 1'b0,
      MODE_BREV = 1'b1
   } addr_mode_e;

   localparam int unsigned DFLT_ADDR_W     = 32;
   localparam int unsigned DFLT_IDX_W      = 16;
   localparam int unsigned DFLT_OFF_W      = 10;
   localparam int unsigned DFLT_WORD_BYTES = 4;

endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   for (genvar i = 0; i < W; i++) begin : g_swap
      assign dout[i] = din[W-1-i];
   end

endmodule

// File: rtl/brev_stepper.sv
module brev_stepper #(
   parameter int unsigned IDX_W = 16
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W-1:0] step,
   output logic [IDX_W-1:0] idx_next
);

   logic [IDX_W-1:0] idx_m;
   logic [IDX_W-1:0] step_m;
   logic [IDX_W-1:0] sum_m;

   bit_mirror #(.W(IDX_W)) u_mir_idx  (.din(idx),   .dout(idx_m));
   bit_mirror #(.W(IDX_W)) u_mir_step (.din(step),  .dout(step_m));

   // carry out of the top bit is dropped by the width of sum_m
   assign sum_m = idx_m + step_m;

   bit_mirror #(.W(IDX_W)) u_mir_sum  (.din(sum_m), .dout(idx_next));

endmodule

// File: rtl/circ_wrapper.sv
module circ_wrapper #(
   parameter int unsigned IDX_W = 16,
   parameter int unsigned OFF_W = 10,
   parameter int unsigned STEP  = 4
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W-1:0] len,
   input  logic [OFF_W-1:0] off,
   output logic [IDX_W-1:0] idx_next,
   output logic [IDX_W-1:0] idx_second,
   output logic             len_zero
);

   localparam int unsigned SW = IDX_W + 2;
   localparam int unsigned NW = IDX_W + 1;

   if (OFF_W >= IDX_W) begin : g_bad_off
      $error("circ_wrapper: OFF_W must be narrower than IDX_W");
   end
   if (STEP == 0 || STEP >= (1 << IDX_W)) begin : g_bad_step
      $error("circ_wrapper: STEP out of range");
   end

   logic signed [SW-1:0] sum_s;
   logic signed [SW-1:0] len_s;
   logic signed [SW-1:0] wrap_s;
   logic [NW-1:0]        nxt_u;
   logic [NW-1:0]        len_u;
   logic [NW-1:0]        nxt_w;

   assign len_s = signed'({2'b00, len});
   assign sum_s = signed'({2'b00, idx}) + signed'({{(SW-OFF_W){off[OFF_W-1]}}, off});

   always_comb begin
      if (sum_s < 0) begin
         wrap_s = sum_s + len_s;
      end else if (sum_s >= len_s) begin
         wrap_s = sum_s - len_s;
      end else begin
         wrap_s = sum_s;
      end
   end

   assign len_u = {1'b0, len};
   assign nxt_u = {1'b0, idx} + NW'(STEP);
   assign nxt_w = (nxt_u >= len_u) ? (nxt_u - len_u) : nxt_u;

   assign len_zero   = (len == '0);
   assign idx_next   = len_zero ? idx : wrap_s[IDX_W-1:0];
   assign idx_second = nxt_w[IDX_W-1:0];

endmodule

// File: rtl/dsp_addr_updater.sv
module dsp_addr_updater
   import dsp_addr_pkg::*;
#(
   parameter int unsigned ADDR_W     = DFLT_ADDR_W,
   parameter int unsigned IDX_W      = DFLT_IDX_W,
   parameter int unsigned OFF_W      = DFLT_OFF_W,
   parameter int unsigned WORD_BYTES = DFLT_WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] ptr_reg,
   input  logic [OFF_W-1:0]  offset,
   output logic              valid,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] second_addr,
   output logic [ADDR_W-1:0] new_ptr,
   output logic              len_err
);

   localparam int unsigned HI_W = ADDR_W - IDX_W;
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

   if (ADDR_W != 2 * IDX_W) begin : g_bad_pack
      $error("dsp_addr_updater: ADDR_W must be twice IDX_W");
   end
   if (OFF_W < 2) begin : g_bad_offw
      $error("dsp_addr_updater: OFF_W too small");
   end

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] hi_field;
   logic [IDX_W-1:0] circ_idx;
   logic [IDX_W-1:0] circ_sec;
   logic             circ_zero;
   logic [IDX_W-1:0] brev_idx;
   logic [ADDR_W-1:0] ea_c;
   logic [ADDR_W-1:0] sec_c;
   logic [IDX_W-1:0]  idx_c;
   logic              err_c;
   addr_mode_e        mode_e;

   assign mode_e   = addr_mode_e'(mode);
   assign idx      = ptr_reg[IDX_W-1:0];
   assign hi_field = ptr_reg[ADDR_W-1:IDX_W];

   circ_wrapper #(
      .IDX_W (IDX_W),
      .OFF_W (OFF_W),
      .STEP  (WORD_BYTES)
   ) u_circ (
      .idx        (idx),
      .len        (hi_field),
      .off        (offset),
      .idx_next   (circ_idx),
      .idx_second (circ_sec),
      .len_zero   (circ_zero)
   );

   brev_stepper #(
      .IDX_W (IDX_W)
   ) u_brev (
      .idx      (idx),
      .step     (hi_field),
      .idx_next (brev_idx)
   );

   assign ea_c = base_addr + {{HI_W{1'b0}}, idx};

   always_comb begin
      if (mode_e == MODE_BREV) begin
         idx_c = brev_idx;
         sec_c = ea_c + WORD_STEP;
         err_c = 1'b0;
      end else if (circ_zero) begin
         idx_c = idx;
         sec_c = ea_c + WORD_STEP;
         err_c = 1'b1;
      end else begin
         idx_c = circ_idx;
         sec_c = base_addr + {{HI_W{1'b0}}, circ_sec};
         err_c = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid       <= 1'b0;
         eff_addr    <= '0;
         second_addr <= '0;
         new_ptr     <= '0;
         len_err     <= 1'b0;
      end else begin
         valid <= start;
         if (start) begin
            eff_addr    <= ea_c;
            second_addr <= sec_c;
            new_ptr     <= {hi_field, idx_c};
            len_err     <= err_c;
         end
      end
   end

endmodule

// File: rtl/dsp_addr_updater_chk.sv
module dsp_addr_updater_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mode,
   input logic [ADDR_W-1:0] base_addr,
   input logic [ADDR_W-1:0] ptr_reg,
   input logic              valid,
   input logic [ADDR_W-1:0] eff_addr,
   input logic [ADDR_W-1:0] second_addr,
   input logic [ADDR_W-1:0] new_ptr,
   input logic              len_err
);

   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);

   p_valid_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(start));

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> ($stable(new_ptr) && $stable(eff_addr) && $stable(second_addr)));

   p_ea_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> eff_addr == $past(base_addr) + {{(ADDR_W-IDX_W){1'b0}}, $past(ptr_reg[IDX_W-1:0])});

   p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> new_ptr[ADDR_W-1:IDX_W] == $past(ptr_reg[ADDR_W-1:IDX_W]));

   p_circ_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !len_err && !$past(mode)) |-> new_ptr[IDX_W-1:0] < new_ptr[ADDR_W-1:IDX_W]);

   p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && len_err) |-> (new_ptr == $past(ptr_reg) && !$past(mode)));

   p_second_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(mode)) |-> second_addr == eff_addr + 32'd4);

endmodule

bind dsp_addr_updater dsp_addr_updater_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .mode        (mode),
   .base_addr   (base_addr),
   .ptr_reg     (ptr_reg),
   .valid       (valid),
   .eff_addr    (eff_addr),
   .second_addr (second_addr),
   .new_ptr     (new_ptr),
   .len_err     (len_err)
);

// File: tb/dsp_addr_updater_test.sv
module dsp_addr_updater_test;

   typedef struct packed {
      logic        mode;
      logic [31:0] base;
      logic [31:0] ptr;
      logic [9:0]  off;
      logic [31:0] ea;
      logic [31:0] sec;
      logic [31:0] nptr;
      logic        err;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // circular, plain step (R4)
      '{1'b0, 32'h1000_0000, 32'h0040_0010, 10'h008, 32'h1000_0010, 32'h1000_0014, 32'h0040_0018, 1'b0},
      // circular, forward past end, second word wraps to 0 (R4 R6)
      '{1'b0, 32'h2000_0000, 32'h0040_003C, 10'h008, 32'h2000_003C, 32'h2000_0000, 32'h0040_0004, 1'b0},
      // circular, backward below zero (R4)
      '{1'b0, 32'h2000_0000, 32'h0040_0004, 10'h3F8, 32'h2000_0004, 32'h2000_0008, 32'h0040_003C, 1'b0},
      // circular, sum equals length (R4)
      '{1'b0, 32'h0000_0100, 32'h0030_0020, 10'h010, 32'h0000_0120, 32'h0000_0124, 32'h0030_0000, 1'b0},
      // circular, most negative offset (R4)
      '{1'b0, 32'h0000_0000, 32'h0300_0100, 10'h200, 32'h0000_0100, 32'h0000_0104, 32'h0300_0200, 1'b0},
      // bit-reverse from zero, offset ignored (R5)
      '{1'b1, 32'h3000_0000, 32'h0008_0000, 10'h155, 32'h3000_0000, 32'h3000_0004, 32'h0008_0008, 1'b0},
      // bit-reverse with reversed carry (R5)
      '{1'b1, 32'h3000_0000, 32'h0008_0008, 10'h000, 32'h3000_0008, 32'h3000_000C, 32'h0008_0004, 1'b0},
      // bit-reverse carry out of bit 15 dropped (R5)
      '{1'b1, 32'h4000_0000, 32'h0001_0001, 10'h3FF, 32'h4000_0001, 32'h4000_0005, 32'h0001_0000, 1'b0},
      // circular zero length error (R7)
      '{1'b0, 32'h5000_0000, 32'h0000_0012, 10'h004, 32'h5000_0012, 32'h5000_0016, 32'h0000_0012, 1'b1},
      // bit-reverse zero step: no error (R7)
      '{1'b1, 32'h5000_0000, 32'h0000_0012, 10'h004, 32'h5000_0012, 32'h5000_0016, 32'h0000_0012, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode = 1'b0;
   logic [31:0] base_addr = '0;
   logic [31:0] ptr_reg = '0;
   logic [9:0]  offset = '0;
   logic        valid;
   logic [31:0] eff_addr;
   logic [31:0] second_addr;
   logic [31:0] new_ptr;
   logic        len_err;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dsp_addr_updater uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mode        (mode),
      .base_addr   (base_addr),
      .ptr_reg     (ptr_reg),
      .offset      (offset),
      .valid       (valid),
      .eff_addr    (eff_addr),
      .second_addr (second_addr),
      .new_ptr     (new_ptr),
      .len_err     (len_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive at negedge, result sampled at the following negedge
   task automatic issue(input logic m, input logic [31:0] b,
                        input logic [31:0] p, input logic [9:0] o);
      @(negedge clk);
      mode = m; base_addr = b; ptr_reg = p; offset = o; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8", "valid in reset", {31'b0, valid}, 32'h0);
      check("R8", "new_ptr in reset", new_ptr, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", "eff_addr after reset", eff_addr, 32'h0);
      check("R8", "second_addr after reset", second_addr, 32'h0);
      check("R8", "len_err after reset", {31'b0, len_err}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].mode, VECS[i].base, VECS[i].ptr, VECS[i].off);
         check("R1", $sformatf("valid v%0d", i), {31'b0, valid}, 32'h1);
         check("R2", $sformatf("eff_addr v%0d", i), eff_addr, VECS[i].ea);
         check("R6", $sformatf("second_addr v%0d", i), second_addr, VECS[i].sec);
         check(VECS[i].mode ? "R5" : "R4", $sformatf("new_ptr v%0d", i), new_ptr, VECS[i].nptr);
         check("R3", $sformatf("upper half v%0d", i), {16'h0, new_ptr[31:16]}, {16'h0, VECS[i].ptr[31:16]});
         check("R7", $sformatf("len_err v%0d", i), {31'b0, len_err}, {31'b0, VECS[i].err});
      end

      // hold: inputs change without start, outputs keep last result (R1)
      mode = 1'b0; base_addr = 32'hDEAD_0000; ptr_reg = 32'h0040_0001; offset = 10'h001;
      @(negedge clk);
      check("R1", "valid low without start", {31'b0, valid}, 32'h0);
      check("R1", "new_ptr held", new_ptr, 32'h0000_0012);
      check("R1", "eff_addr held", eff_addr, 32'h5000_0012);

      // back-to-back strobes (R1)
      @(negedge clk);
      mode = 1'b0; base_addr = 32'h0; ptr_reg = 32'h0010_0002; offset = 10'h003; start = 1'b1;
      @(negedge clk);
      check("R1", "b2b first valid", {31'b0, valid}, 32'h1);
      check("R4", "b2b first ptr", new_ptr, 32'h0010_0005);
      ptr_reg = 32'h0010_000E; offset = 10'h004;
      @(negedge clk);
      start = 1'b0;
      check("R1", "b2b second valid", {31'b0, valid}, 32'h1);
      check("R4", "b2b second ptr", new_ptr, 32'h0010_0002);
      check("R6", "b2b second word", second_addr, 32'h0000_0002);
      @(negedge clk);
      check("R1", "valid drops", {31'b0, valid}, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule